// File: doc/BRIEF.md
# Clocked Serial Shifter with Completion Interrupt

This block is an 8-bit synchronous serial port for a small controller. A data register loaded by software is shifted out, least significant bit first, on a serial output pin. In the same transfer the register fills from a serial input pin, so one transfer both sends and receives a byte. A shift clock paces each bit. The shift clock comes from an internal divider of the system clock or from an external clock pin.

Software starts a transfer by setting a run bit. After the eighth bit the block clears run by itself and sets a completion flag. An interrupt request line is raised when the flag and an enable bit are both set. Software clears the flag by writing zero to it. A stop written in the cycle the last bit lands suppresses the flag. Enabling the interrupt while the flag is already set raises the request on the next cycle.

Top module: `ser8_shift_unit`

## Requirements
- R1: After reset the data readback is 0x00, the control readback is 0x00, `sout` is 1, `sck_out` is 1 and `irq` is 0.
- R2: Control byte layout, used for both writes and readback: bit0 run, bit1 completion flag, bit2 interrupt enable, bits 4:3 divider select, bit5 external clock select, bits 7:6 read as 0. On each falling shift-clock edge, `sout` takes bit 0 of the data register. The byte therefore leaves LSB first, one bit per shift-clock period.
- R3: On each rising shift-clock edge, `sin` enters the data register at bit 7 and the register moves one place toward bit 0. After 8 bits, the first bit received sits at bit 0.
- R4: The 8th rising edge of a transfer sets the completion flag and clears run. This happens whether or not the interrupt enable is set.
- R5: A control write with bit1 = 0 clears the flag, and one with bit1 = 1 leaves it unchanged. A completion in the same cycle as a clearing write still sets the flag.
- R6: `irq` is 1 exactly when flag and enable are both 1, updated in the cycle after the event that changes either of them.
- R7: Writing enable = 1 while the flag is already 1 raises `irq` on the next cycle.
- R8: A control write with bit0 = 0 that lands in the cycle of the 8th rising edge leaves the flag at 0.
- R9: Divider select values 0, 1, 2 and 3 give a shift-clock period of 2, 8, 32 and 64 system clocks. The shift clock idles high, and the first edge after a start is a falling edge half a period later.
- R10: With bit5 = 1, the edges of `ext_sck` clock the transfer after a two-stage synchronizer, and `sck_out` stays at 1.
- R11: A data write while run is 1 is ignored. The data readback always shows the live shift register.
- R12: Every start resets the bit count. A transfer restarted after an abort therefore completes after exactly 8 more rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Data register write value |
| data_rdata | output | 8 | Live shift register contents |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value (layout in R2) |
| ctl_rdata | output | 8 | Control and status readback |
| sin | input | 1 | Serial data in |
| sout | output | 1 | Serial data out |
| ext_sck | input | 1 | External shift clock |
| sck_out | output | 1 | Internal shift clock as driven to the pin |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the stop write that lands in exactly the cycle of the eighth rising edge. One cycle early, the transfer aborts without completing. One cycle late, the flag is already set. The bench uses the fastest divider, where the edge positions follow from the start cycle alone. It issues the stop sixteen cycles after the start, and then repeats the run with the stop one cycle later to show that the flag would otherwise have been set. The stop writes keep the flag bit at 1, so the flag stays clear only because of suppression.

// File: rtl/ser8_pkg.sv
package ser8_pkg;
  localparam int CTL_W      = 8;
  localparam int BIT_RUN    = 0;
  localparam int BIT_FLAG   = 1;
  localparam int BIT_IE     = 2;
  localparam int BIT_SEL_LO = 3;
  localparam int BIT_EXT    = 5;

  typedef struct packed {
    logic       ext;
    logic [1:0] sel;
    logic       ie;
    logic       flag;
    logic       run;
  } ctl_t;

  // system clocks per shift-clock half period for each divider select
  function automatic int half_period(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 16;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/ser8_clkgen.sv
module ser8_clkgen #(
  parameter int DIV_W  = 6,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       ext_mode,
  input  logic [1:0] sel,
  input  logic       ext_sck,
  output logic       fall_ev,
  output logic       rise_ev,
  output logic       sck_out
);
  localparam int CHAIN = SYNC_N + 1;

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] half_m1;
  logic             sck_q;
  logic [CHAIN-1:0] sync_q;
  logic             tick;
  logic             ext_fall, ext_rise;

  assign half_m1 = DIV_W'(ser8_pkg::half_period(sel) - 1);
  assign tick    = run && !ext_mode && (div_cnt == half_m1);

  // sync_q[SYNC_N-1] is the synchronized level, sync_q[SYNC_N] its previous value
  assign ext_fall = run && ext_mode && sync_q[SYNC_N] && !sync_q[SYNC_N-1];
  assign ext_rise = run && ext_mode && !sync_q[SYNC_N] && sync_q[SYNC_N-1];

  assign fall_ev = (tick && sck_q) || ext_fall;
  assign rise_ev = (tick && !sck_q) || ext_rise;
  assign sck_out = sck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '1;
      div_cnt <= '0;
      sck_q   <= 1'b1;
    end else begin
      sync_q <= {sync_q[CHAIN-2:0], ext_sck};
      if (!run || ext_mode) begin
        div_cnt <= '0;
        sck_q   <= 1'b1;
      end else if (tick) begin
        div_cnt <= '0;
        sck_q   <= ~sck_q;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  // R9
  edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fall_ev, rise_ev}));

  // R10
  ext_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_mode && $past(ext_mode)) |-> sck_out);
endmodule

// File: rtl/ser8_shifter.sv
module ser8_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              run,
  input  logic              fall_ev,
  input  logic              rise_ev,
  input  logic              data_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sin,
  output logic [DATA_W-1:0] shreg,
  output logic              sout,
  output logic              done_ev
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] bit_cnt;

  assign done_ev = rise_ev && (bit_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      bit_cnt <= '0;
      sout    <= 1'b1;
    end else begin
      if (start)
        bit_cnt <= '0;
      else if (rise_ev)
        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;

      if (rise_ev)
        shreg <= {sin, shreg[DATA_W-1:1]};
      else if (data_we && !run)
        shreg <= wdata;

      if (fall_ev)
        sout <= shreg[0];
    end
  end

  // R2
  tx_bit_chk: assert property (@(posedge clk) disable iff (rst)
    fall_ev |=> (sout == $past(shreg[0])));

  // R3
  rx_msb_chk: assert property (@(posedge clk) disable iff (rst)
    rise_ev |=> (shreg[DATA_W-1] == $past(sin)));

  // R11
  busy_write_chk: assert property (@(posedge clk) disable iff (rst)
    (run && data_we && !rise_ev) |=> $stable(shreg));
endmodule

// File: rtl/ser8_ctrl.sv
module ser8_ctrl
  import ser8_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             done_ev,
  output ctl_t             ctl,
  output logic             start,
  output logic             irq
);
  logic stop_wr;
  ctl_t ctl_d;

  assign start   = ctl_we && ctl_wdata[BIT_RUN] && !ctl.run;
  assign stop_wr = ctl_we && !ctl_wdata[BIT_RUN];

  always_comb begin
    ctl_d = ctl;
    if (done_ev)     ctl_d.run = 1'b0;
    else if (ctl_we) ctl_d.run = ctl_wdata[BIT_RUN];

    if (done_ev && !stop_wr)              ctl_d.flag = 1'b1;
    else if (ctl_we && !ctl_wdata[BIT_FLAG]) ctl_d.flag = 1'b0;

    if (ctl_we) begin
      ctl_d.ie  = ctl_wdata[BIT_IE];
      ctl_d.sel = ctl_wdata[BIT_SEL_LO+1:BIT_SEL_LO];
      ctl_d.ext = ctl_wdata[BIT_EXT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= '0;
      irq <= 1'b0;
    end else begin
      ctl <= ctl_d;
      irq <= ctl_d.flag && ctl_d.ie;
    end
  end

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (done_ev && !stop_wr) |=> (ctl.flag && !ctl.run));

  // R8
  stop_suppress_chk: assert property (@(posedge clk) disable iff (rst)
    (done_ev && stop_wr && !ctl.flag) |=> !ctl.flag);

  // R7
  ie_late_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wdata[BIT_IE] && ctl_wdata[BIT_FLAG] && ctl.flag) |=> irq);

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(done_ev || ctl_we));
endmodule

// File: rtl/ser8_shift_unit.sv
module ser8_shift_unit
  import ser8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 6,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_wdata,
  output logic [DATA_W-1:0] data_rdata,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic              sin,
  output logic              sout,
  input  logic              ext_sck,
  output logic              sck_out,
  output logic              irq
);
  localparam int CTL_USED = $bits(ctl_t);

  ctl_t ctl;
  logic start, fall_ev, rise_ev, done_ev;

  ser8_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .done_ev   (done_ev),
    .ctl       (ctl),
    .start     (start),
    .irq       (irq)
  );

  ser8_clkgen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .run      (ctl.run),
    .ext_mode (ctl.ext),
    .sel      (ctl.sel),
    .ext_sck  (ext_sck),
    .fall_ev  (fall_ev),
    .rise_ev  (rise_ev),
    .sck_out  (sck_out)
  );

  ser8_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .run     (ctl.run),
    .fall_ev (fall_ev),
    .rise_ev (rise_ev),
    .data_we (data_we),
    .wdata   (data_wdata),
    .sin     (sin),
    .shreg   (data_rdata),
    .sout    (sout),
    .done_ev (done_ev)
  );

  assign ctl_rdata = {{(CTL_W-CTL_USED){1'b0}}, ctl};
endmodule

// File: tb/ser8_shift_unit_bench.sv
module ser8_shift_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       data_we = 1'b0;
  logic [7:0] data_wdata = 8'h00;
  logic [7:0] data_rdata;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       sin = 1'b0;
  logic       sout;
  logic       ext_sck = 1'b1;
  logic       sck_out;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit seen_edge = 0;

  // behavioural reference state
  int m_run, m_flag, m_ie, m_sel, m_ext, m_data, m_cnt, m_ph, m_sck, m_sout, m_irq;
  int m_s1, m_s2, m_s3;

  ser8_shift_unit u_ser8_shift_unit (
    .clk(clk), .rst(rst),
    .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .sin(sin), .sout(sout), .ext_sck(ext_sck), .sck_out(sck_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] cv(input bit run, input bit flag, input bit ie,
                                    input int sel, input bit ext);
    return {2'b00, ext, 2'(sel), ie, flag, run};
  endfunction

  task automatic ctl_write(input logic [7:0] v);
    ctl_wdata = v;
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic data_write(input logic [7:0] v);
    data_wdata = v;
    data_we = 1'b1;
    @(negedge clk);
    data_we = 1'b0;
  endtask

  always @(posedge clk) begin : ref_model
    int half;
    bit fall, rise, done, stop_wr, start;
    seen_edge = 1;
    if (rst) begin
      m_run = 0; m_flag = 0; m_ie = 0; m_sel = 0; m_ext = 0; m_data = 0;
      m_cnt = 0; m_ph = 0; m_sck = 1; m_sout = 1; m_irq = 0;
      m_s1 = 1; m_s2 = 1; m_s3 = 1;
    end else begin
      half = (m_sel == 3) ? 32 : (1 << (2 * m_sel));
      fall = 0; rise = 0;
      if (m_run != 0) begin
        if (m_ext != 0) begin
          fall = (m_s3 == 1) && (m_s2 == 0);
          rise = (m_s3 == 0) && (m_s2 == 1);
        end else if (m_ph == half - 1) begin
          fall = (m_sck == 1);
          rise = (m_sck == 0);
        end
      end
      if (m_run == 0 || m_ext != 0) begin m_ph = 0; m_sck = 1; end
      else if (m_ph == half - 1) begin m_ph = 0; m_sck = 1 - m_sck; end
      else m_ph++;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(ext_sck);
      done    = rise && (m_cnt == 7);
      stop_wr = ctl_we && !ctl_wdata[0];
      start   = ctl_we && ctl_wdata[0] && (m_run == 0);
      if (fall) m_sout = m_data % 2;
      if (rise) m_data = (int'(sin) * 128) + (m_data / 2);
      else if (data_we && m_run == 0) m_data = int'(data_wdata);
      if (start) m_cnt = 0;
      else if (rise) m_cnt = (m_cnt + 1) % 8;
      if (done && !stop_wr) m_flag = 1;
      else if (ctl_we && !ctl_wdata[1]) m_flag = 0;
      if (done) m_run = 0;
      else if (ctl_we) m_run = int'(ctl_wdata[0]);
      if (ctl_we) begin
        m_ie  = int'(ctl_wdata[2]);
        m_sel = int'(ctl_wdata[4:3]);
        m_ext = int'(ctl_wdata[5]);
      end
      m_irq = m_flag * m_ie;
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (seen_edge && !rst) begin
      chk("R3 data_rdata vs model", 32'(data_rdata), 32'(m_data));
      chk("R2 sout vs model", 32'(sout), 32'(m_sout));
      chk("R5 ctl_rdata vs model", 32'(ctl_rdata),
          32'(m_run + 2*m_flag + 4*m_ie + 8*m_sel + 32*m_ext));
      chk("R6 irq vs model", 32'(irq), 32'(m_irq));
      chk("R9 sck_out vs model", 32'(sck_out), 32'((m_ext != 0) ? 1 : m_sck));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] txb;
    logic [7:0] rxpat;
    int n;
    bit prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    chk("R1 data after reset", 32'(data_rdata), 32'h00);
    chk("R1 ctl after reset", 32'(ctl_rdata), 32'h00);
    chk("R1 sout after reset", 32'(sout), 32'h1);
    chk("R1 sck_out after reset", 32'(sck_out), 32'h1);
    chk("R1 irq after reset", 32'(irq), 32'h0);

    // full-duplex byte at divide-by-8, interrupt disabled
    rxpat = 8'h4D;
    data_write(8'hA5);
    ctl_write(cv(1, 1, 0, 1, 0));
    for (int i = 0; i < 8; i++) begin
      while (sck_out) @(negedge clk);
      txb[i] = sout;
      sin = rxpat[i];
      if (i == 3) data_write(8'h77);
      while (!sck_out) @(negedge clk);
    end
    chk("R2 transmitted byte LSB first", 32'(txb), 32'hA5);
    chk("R3 received byte", 32'(data_rdata), 32'(rxpat));
    chk("R11 busy data write ignored", 32'(data_rdata), 32'h4D);
    chk("R4 flag set", 32'(ctl_rdata[1]), 32'h1);
    chk("R4 run self-cleared", 32'(ctl_rdata[0]), 32'h0);
    chk("R4 irq stays low with enable off", 32'(irq), 32'h0);

    // late enable with flag pending
    ctl_write(cv(0, 1, 1, 1, 0));
    chk("R7 irq raised on enable", 32'(irq), 32'h1);
    ctl_write(cv(0, 1, 1, 1, 0));
    chk("R5 writing 1 keeps flag", 32'(ctl_rdata[1]), 32'h1);
    ctl_write(cv(0, 0, 1, 1, 0));
    chk("R5 writing 0 clears flag", 32'(ctl_rdata[1]), 32'h0);
    chk("R6 irq drops with flag", 32'(irq), 32'h0);

    // completion with enable on at divide-by-2
    data_write(8'h3C);
    ctl_write(cv(1, 1, 1, 0, 0));
    while (ctl_rdata[0]) @(negedge clk);
    chk("R6 irq on completion", 32'(irq), 32'h1);
    ctl_write(cv(0, 0, 0, 0, 0));

    // shift-clock period for every divider select
    for (int s = 0; s < 4; s++) begin
      ctl_write(cv(1, 1, 0, s, 0));
      while (sck_out) @(negedge clk);
      n = 0;
      while (!sck_out) begin @(negedge clk); n++; end
      while (sck_out) begin @(negedge clk); n++; end
      chk("R9 shift-clock period", 32'(n), (s == 0) ? 2 : (s == 1) ? 8 : (s == 2) ? 32 : 64);
      while (ctl_rdata[0]) @(negedge clk);
      ctl_write(cv(0, 0, 0, s, 0));
    end

    // stop coinciding with the eighth rising edge
    ctl_write(cv(1, 1, 0, 0, 0));
    repeat (15) @(negedge clk);
    ctl_write(cv(0, 1, 0, 0, 0));
    chk("R8 flag suppressed by coincident stop", 32'(ctl_rdata[1]), 32'h0);
    chk("R8 run low after coincident stop", 32'(ctl_rdata[0]), 32'h0);
    ctl_write(cv(1, 1, 0, 0, 0));
    repeat (16) @(negedge clk);
    ctl_write(cv(0, 1, 0, 0, 0));
    chk("R8 stop one cycle late leaves flag set", 32'(ctl_rdata[1]), 32'h1);
    ctl_write(cv(0, 0, 0, 1, 0));

    // abort then restart
    sin = 1'b1;
    ctl_write(cv(1, 1, 0, 1, 0));
    n = 0;
    prev = sck_out;
    while (n < 3) begin
      @(negedge clk);
      if (!prev && sck_out) n++;
      prev = sck_out;
    end
    ctl_write(cv(0, 1, 0, 1, 0));
    repeat (3) @(negedge clk);
    chk("R12 abort leaves flag clear", 32'(ctl_rdata[1]), 32'h0);
    data_write(8'h00);
    ctl_write(cv(1, 1, 0, 1, 0));
    n = 0;
    prev = sck_out;
    while (ctl_rdata[0]) begin
      @(negedge clk);
      if (!prev && sck_out) n++;
      prev = sck_out;
    end
    chk("R12 rising edges after restart", 32'(n), 32'd8);
    chk("R12 data after restart", 32'(data_rdata), 32'hFF);
    ctl_write(cv(0, 0, 0, 0, 0));

    // external shift clock
    rxpat = 8'hB2;
    ctl_write(cv(0, 0, 0, 0, 1));
    data_write(8'h96);
    ctl_write(cv(1, 1, 0, 0, 1));
    for (int i = 0; i < 8; i++) begin
      ext_sck = 1'b0;
      repeat (6) @(negedge clk);
      txb[i] = sout;
      sin = rxpat[i];
      ext_sck = 1'b1;
      repeat (6) @(negedge clk);
    end
    chk("R10 external clock transmit", 32'(txb), 32'h96);
    chk("R10 external clock receive", 32'(data_rdata), 32'(rxpat));
    chk("R10 external clock completion flag", 32'(ctl_rdata[1:0]), 32'h2);
    chk("R10 sck_out held high", 32'(sck_out), 32'h1);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule